// File: doc/BRIEF.md
# Indirect Debug Access Port for a Check-Bit Protected Buffer RAM

This block lets a register bus reach every word of an internal 64-entry buffer RAM without a direct memory window. Each word holds 64 data bits and 8 check bits. Software stages a data word and a check byte in two holding registers. It then writes a command that names the target word and the operation. A status bit shows when the access is in flight and when it has finished. A read leaves the stored word in the holding registers for software to collect.

A command may either store the check byte that software supplied, or store check bits generated from the data. Storing the supplied byte lets software plant a parity error on purpose. The RAM also has a functional read port that checks per-byte even parity on every word it returns. When that check fails, the block raises a one-cycle error strobe. It also records the address of the first failing read in a log, which holds until software clears it.

Top module: `dbg_mem_port`

## Requirements
- R1: After reset, `acc_done` is 1, `log_valid` is 0, `perr_strobe` is 0 and `fn_valid` is 0.
- R2: A command addresses RAM word `{cmd_chan, cmd_entry}`: the channel forms address bits 5:4 and the entry forms bits 3:0. `fn_addr` uses the same 6-bit address space.
- R3: A command write accepted while `acc_done` is 1 makes `acc_done` read 0 for exactly the two following cycles, after which it reads 1 again.
- R4: A command write that arrives while `acc_done` is 0 is ignored. It does not change the access in flight or its timing, and it writes nothing to the RAM.
- R5: A write command (`cmd_is_read` = 0) with `cmd_raw_chk` = 0 stores the data register together with generated check bits. Check bit i is the XOR of data bits 8i+7 down to 8i, which gives each byte even parity.
- R6: A write command with `cmd_raw_chk` = 1 stores the check register unchanged as the check bits.
- R7: A read command (`cmd_is_read` = 1) loads the stored data and check bits into the data and check registers by the time `acc_done` returns to 1.
- R8: A pulse on `fn_re` makes `fn_valid` high in the next cycle, with the stored data on `fn_data`. If the stored check bits differ from the bits generated from that data, `perr_strobe` is high in that same single cycle, whether or not the log already holds an address.
- R9: The first parity error sets `log_valid` and records its address in `log_addr`. Later errors leave the log unchanged while it is valid.
- R10: A `perr_clr` pulse empties the log and re-arms it. An error strobe in the same cycle as the clear is recorded as the new first error.
- R11: `dat_we` and `chk_we` load the data and check registers, which read back on `dat_rval` and `chk_rval` and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dat_we | input | 1 | Load the data register |
| dat_wval | input | 64 | Value for the data register |
| chk_we | input | 1 | Load the check register |
| chk_wval | input | 8 | Value for the check register |
| cmd_we | input | 1 | Command write; starts an access when idle |
| cmd_is_read | input | 1 | Command type: 1 read, 0 write |
| cmd_raw_chk | input | 1 | 1 stores the check register as supplied; 0 stores generated check bits |
| cmd_entry | input | 4 | Entry index, address bits 3:0 |
| cmd_chan | input | 2 | Channel number, address bits 5:4 |
| perr_clr | input | 1 | Write-1 to the parity error status bit: clears and re-arms the log |
| fn_re | input | 1 | Functional read request |
| fn_addr | input | 6 | Functional read address |
| acc_done | output | 1 | Status: 0 busy, 1 done |
| dat_rval | output | 64 | Data register readback |
| chk_rval | output | 8 | Check register readback |
| fn_valid | output | 1 | Functional read data valid |
| fn_data | output | 64 | Functional read data |
| perr_strobe | output | 1 | One-cycle parity error strobe |
| log_valid | output | 1 | The log holds an error address |
| log_addr | output | 6 | Address of the first logged error |

## Verification
The bench writes two words that differ only in the channel field. A design that swapped channel and entry, or dropped one of them, would return the wrong word on the functional port. It sends a second command during the busy window. A design that accepted it would overwrite a word that must stay intact, or would stretch the busy window. It plants errors with raw check bytes and reads two bad words in a row. A design that gated the strobe on an empty log would miss the second strobe, and one that kept overwriting the log would report the later address. It also clears the log in the same cycle as a fresh error. A design that gave the clear priority would be left with an empty log.

// File: rtl/dbg_mem_pkg.sv
package dbg_mem_pkg;

    // Command sequencer phases; the encoding is internal only.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACCESS  = 2'd1,
        PH_CAPTURE = 2'd2
    } phase_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/dbg_mem_parity_gen.sv
module dbg_mem_parity_gen #(
    parameter int DATA_W = 64,
    localparam int CHK_W = DATA_W / dbg_mem_pkg::BYTE_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);
    // One even-parity bit per byte lane.
    for (genvar g = 0; g < CHK_W; g++) begin : g_lane
        assign chk_o[g] = ^data_i[g*dbg_mem_pkg::BYTE_W +: dbg_mem_pkg::BYTE_W];
    end
endmodule

// File: rtl/dbg_mem_array.sv
module dbg_mem_array #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 72,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              dbg_re_i,
    input  logic [ADDR_W-1:0] dbg_raddr_i,
    output logic [WORD_W-1:0] dbg_rdata_o,
    input  logic              fn_re_i,
    input  logic [ADDR_W-1:0] fn_raddr_i,
    output logic [WORD_W-1:0] fn_rdata_o
);
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] dbg_rdata_q;
    logic [WORD_W-1:0] fn_rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        if (dbg_re_i) begin
            dbg_rdata_q <= mem_q[dbg_raddr_i];
        end
        if (fn_re_i) begin
            fn_rdata_q <= mem_q[fn_raddr_i];
        end
    end

    assign dbg_rdata_o = dbg_rdata_q;
    assign fn_rdata_o  = fn_rdata_q;
endmodule

// File: rtl/dbg_mem_ctrl.sv
module dbg_mem_ctrl
    import dbg_mem_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int ENTRY_W = 4,
    parameter int CHAN_W  = 2,
    localparam int CHK_W  = DATA_W / BYTE_W,
    localparam int WORD_W = DATA_W + CHK_W,
    localparam int ADDR_W = ENTRY_W + CHAN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dat_we_i,
    input  logic [DATA_W-1:0]  dat_wval_i,
    input  logic               chk_we_i,
    input  logic [CHK_W-1:0]   chk_wval_i,
    input  logic               cmd_we_i,
    input  logic               cmd_is_read_i,
    input  logic               cmd_raw_chk_i,
    input  logic [ENTRY_W-1:0] cmd_entry_i,
    input  logic [CHAN_W-1:0]  cmd_chan_i,
    input  logic [WORD_W-1:0]  ram_rdata_i,
    output logic               ram_we_o,
    output logic               ram_re_o,
    output logic [ADDR_W-1:0]  ram_addr_o,
    output logic [WORD_W-1:0]  ram_wdata_o,
    output logic               done_o,
    output logic [DATA_W-1:0]  dat_rval_o,
    output logic [CHK_W-1:0]   chk_rval_o
);
    typedef struct packed {
        phase_e              phase;
        logic                is_rd;
        logic                raw_chk;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic [CHK_W-1:0]    chk;
    } ctrl_s;

    ctrl_s st_d, st_q;
    logic [CHK_W-1:0] gen_chk;

    dbg_mem_parity_gen #(.DATA_W(DATA_W)) i_gen (
        .data_i (st_q.data),
        .chk_o  (gen_chk)
    );

    always_comb begin
        st_d = st_q;
        if (dat_we_i) st_d.data = dat_wval_i;
        if (chk_we_i) st_d.chk  = chk_wval_i;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (cmd_we_i) begin
                    st_d.phase   = PH_ACCESS;
                    st_d.is_rd   = cmd_is_read_i;
                    st_d.raw_chk = cmd_raw_chk_i;
                    st_d.addr    = {cmd_chan_i, cmd_entry_i};
                end
            end
            PH_ACCESS: st_d.phase = PH_CAPTURE;
            PH_CAPTURE: begin
                st_d.phase = PH_IDLE;
                if (st_q.is_rd) begin
                    st_d.data = ram_rdata_i[DATA_W-1:0];
                    st_d.chk  = ram_rdata_i[WORD_W-1:DATA_W];
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, is_rd: 1'b0, raw_chk: 1'b0,
                      addr: '0, data: '0, chk: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_we_o    = (st_q.phase == PH_ACCESS) && !st_q.is_rd;
    assign ram_re_o    = (st_q.phase == PH_ACCESS) &&  st_q.is_rd;
    assign ram_addr_o  = st_q.addr;
    assign ram_wdata_o = {(st_q.raw_chk ? st_q.chk : gen_chk), st_q.data};
    assign done_o      = (st_q.phase == PH_IDLE);
    assign dat_rval_o  = st_q.data;
    assign chk_rval_o  = st_q.chk;

    // R3
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |=> !done_o ##1 done_o);

    // R4
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && cmd_we_i) |=> $stable(ram_addr_o));

    // R4
    single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_o || ram_re_o) |=> !(ram_we_o || ram_re_o));
endmodule

// File: rtl/dbg_mem_chklog.sv
module dbg_mem_chklog #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 6,
    localparam int CHK_W  = DATA_W / dbg_mem_pkg::BYTE_W,
    localparam int WORD_W = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fn_re_i,
    input  logic [ADDR_W-1:0] fn_addr_i,
    input  logic [WORD_W-1:0] fn_word_i,
    input  logic              clr_i,
    output logic              fn_valid_o,
    output logic              perr_o,
    output logic              log_valid_o,
    output logic [ADDR_W-1:0] log_addr_o
);
    typedef struct packed {
        logic              rd_vld;
        logic [ADDR_W-1:0] rd_addr;
        logic              log_vld;
        logic [ADDR_W-1:0] log_addr;
    } log_s;

    log_s lg_d, lg_q;
    logic [CHK_W-1:0] exp_chk;
    logic             mismatch;

    dbg_mem_parity_gen #(.DATA_W(DATA_W)) i_gen (
        .data_i (fn_word_i[DATA_W-1:0]),
        .chk_o  (exp_chk)
    );

    assign mismatch = lg_q.rd_vld && (exp_chk != fn_word_i[WORD_W-1:DATA_W]);

    always_comb begin
        lg_d         = lg_q;
        lg_d.rd_vld  = fn_re_i;
        if (fn_re_i) lg_d.rd_addr = fn_addr_i;
        if (clr_i) lg_d.log_vld = 1'b0;
        if (mismatch && (!lg_q.log_vld || clr_i)) begin
            lg_d.log_vld  = 1'b1;
            lg_d.log_addr = lg_q.rd_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lg_q <= '0;
        end else begin
            lg_q <= lg_d;
        end
    end

    assign fn_valid_o  = lg_q.rd_vld;
    assign perr_o      = mismatch;
    assign log_valid_o = lg_q.log_vld;
    assign log_addr_o  = lg_q.log_addr;

    // R8
    strobe_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |=> log_valid_o);

    // R9
    log_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (log_valid_o && !clr_i) |=> (log_valid_o && $stable(log_addr_o)));

    // R10
    log_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !perr_o) |=> !log_valid_o);
endmodule

// File: rtl/dbg_mem_port.sv
module dbg_mem_port #(
    parameter int DATA_W  = 64,
    parameter int ENTRY_W = 4,
    parameter int CHAN_W  = 2,
    localparam int CHK_W  = DATA_W / dbg_mem_pkg::BYTE_W,
    localparam int WORD_W = DATA_W + CHK_W,
    localparam int ADDR_W = ENTRY_W + CHAN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dat_we,
    input  logic [DATA_W-1:0]  dat_wval,
    input  logic               chk_we,
    input  logic [CHK_W-1:0]   chk_wval,
    input  logic               cmd_we,
    input  logic               cmd_is_read,
    input  logic               cmd_raw_chk,
    input  logic [ENTRY_W-1:0] cmd_entry,
    input  logic [CHAN_W-1:0]  cmd_chan,
    input  logic               perr_clr,
    input  logic               fn_re,
    input  logic [ADDR_W-1:0]  fn_addr,
    output logic               acc_done,
    output logic [DATA_W-1:0]  dat_rval,
    output logic [CHK_W-1:0]   chk_rval,
    output logic               fn_valid,
    output logic [DATA_W-1:0]  fn_data,
    output logic               perr_strobe,
    output logic               log_valid,
    output logic [ADDR_W-1:0]  log_addr
);
    logic              ram_we, ram_re;
    logic [ADDR_W-1:0] ram_addr;
    logic [WORD_W-1:0] ram_wdata, dbg_rdata, fn_word;

    dbg_mem_ctrl #(.DATA_W(DATA_W), .ENTRY_W(ENTRY_W), .CHAN_W(CHAN_W)) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .dat_we_i      (dat_we),
        .dat_wval_i    (dat_wval),
        .chk_we_i      (chk_we),
        .chk_wval_i    (chk_wval),
        .cmd_we_i      (cmd_we),
        .cmd_is_read_i (cmd_is_read),
        .cmd_raw_chk_i (cmd_raw_chk),
        .cmd_entry_i   (cmd_entry),
        .cmd_chan_i    (cmd_chan),
        .ram_rdata_i   (dbg_rdata),
        .ram_we_o      (ram_we),
        .ram_re_o      (ram_re),
        .ram_addr_o    (ram_addr),
        .ram_wdata_o   (ram_wdata),
        .done_o        (acc_done),
        .dat_rval_o    (dat_rval),
        .chk_rval_o    (chk_rval)
    );

    dbg_mem_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_array (
        .clk         (clk),
        .we_i        (ram_we),
        .waddr_i     (ram_addr),
        .wdata_i     (ram_wdata),
        .dbg_re_i    (ram_re),
        .dbg_raddr_i (ram_addr),
        .dbg_rdata_o (dbg_rdata),
        .fn_re_i     (fn_re),
        .fn_raddr_i  (fn_addr),
        .fn_rdata_o  (fn_word)
    );

    dbg_mem_chklog #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chklog (
        .clk         (clk),
        .rst_n       (rst_n),
        .fn_re_i     (fn_re),
        .fn_addr_i   (fn_addr),
        .fn_word_i   (fn_word),
        .clr_i       (perr_clr),
        .fn_valid_o  (fn_valid),
        .perr_o      (perr_strobe),
        .log_valid_o (log_valid),
        .log_addr_o  (log_addr)
    );

    assign fn_data = fn_word[DATA_W-1:0];

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (acc_done && !log_valid));
endmodule

// File: tb/test_dbg_mem_port.sv
module test_dbg_mem_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dat_we = 0, chk_we = 0, cmd_we = 0, cmd_is_read = 0, cmd_raw_chk = 0;
    logic [63:0] dat_wval = '0;
    logic [7:0]  chk_wval = '0;
    logic [3:0]  cmd_entry = '0;
    logic [1:0]  cmd_chan = '0;
    logic        perr_clr = 0, fn_re = 0;
    logic [5:0]  fn_addr = '0;
    logic        acc_done, fn_valid, perr_strobe, log_valid;
    logic [63:0] dat_rval, fn_data;
    logic [7:0]  chk_rval;
    logic [5:0]  log_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dbg_mem_port i_dbg_mem_port (
        .clk(clk), .rst_n(rst_n), .dat_we(dat_we), .dat_wval(dat_wval),
        .chk_we(chk_we), .chk_wval(chk_wval), .cmd_we(cmd_we),
        .cmd_is_read(cmd_is_read), .cmd_raw_chk(cmd_raw_chk),
        .cmd_entry(cmd_entry), .cmd_chan(cmd_chan), .perr_clr(perr_clr),
        .fn_re(fn_re), .fn_addr(fn_addr), .acc_done(acc_done),
        .dat_rval(dat_rval), .chk_rval(chk_rval), .fn_valid(fn_valid),
        .fn_data(fn_data), .perr_strobe(perr_strobe), .log_valid(log_valid),
        .log_addr(log_addr)
    );

    function automatic logic [7:0] even_chk(input logic [63:0] d);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) p[i] = ^d[i*8 +: 8];
        return p;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_regs(input logic [63:0] d, input logic [7:0] c);
        @(negedge clk);
        dat_we = 1; dat_wval = d; chk_we = 1; chk_wval = c;
        @(negedge clk);
        dat_we = 0; chk_we = 0;
        check(dat_rval == d, "R11 data readback", dat_rval, d);
        check(chk_rval == c, "R11 check readback", {56'd0, chk_rval}, {56'd0, c});
    endtask

    // Issues a command and checks the R3 busy window.
    task automatic run_cmd(input bit rd, input bit raw, input logic [1:0] ch,
                           input logic [3:0] en);
        @(negedge clk);
        cmd_we = 1; cmd_is_read = rd; cmd_raw_chk = raw; cmd_chan = ch; cmd_entry = en;
        @(negedge clk);
        cmd_we = 0;
        check(acc_done == 1'b0, "R3 busy cycle 1", {63'd0, acc_done}, 64'd0);
        @(negedge clk);
        check(acc_done == 1'b0, "R3 busy cycle 2", {63'd0, acc_done}, 64'd0);
        @(negedge clk);
        check(acc_done == 1'b1, "R3 done", {63'd0, acc_done}, 64'd1);
    endtask

    task automatic fn_read(input logic [5:0] a, input logic [63:0] exp_d,
                           input bit exp_err, input string req);
        @(negedge clk);
        fn_re = 1; fn_addr = a;
        @(negedge clk);
        fn_re = 0;
        check(fn_valid == 1'b1, {req, " fn_valid"}, {63'd0, fn_valid}, 64'd1);
        check(fn_data == exp_d, {req, " fn_data"}, fn_data, exp_d);
        check(perr_strobe == exp_err, {req, " strobe"}, {63'd0, perr_strobe}, {63'd0, exp_err});
        @(negedge clk);
        check(perr_strobe == 1'b0, {req, " strobe one cycle"}, {63'd0, perr_strobe}, 64'd0);
    endtask

    task automatic t_reset();
        check(acc_done == 1'b1, "R1 done", {63'd0, acc_done}, 64'd1);
        check(log_valid == 1'b0, "R1 log", {63'd0, log_valid}, 64'd0);
        check(perr_strobe == 1'b0, "R1 strobe", {63'd0, perr_strobe}, 64'd0);
        check(fn_valid == 1'b0, "R1 fn_valid", {63'd0, fn_valid}, 64'd0);
    endtask

    task automatic t_gen_write_read();
        logic [63:0] d = 64'h0123_4567_89AB_CDEF;
        load_regs(d, 8'h00);
        run_cmd(0, 0, 2'd0, 4'd3);
        load_regs(64'h0, 8'hFF);
        run_cmd(1, 0, 2'd0, 4'd3);
        check(dat_rval == d, "R7 read data", dat_rval, d);
        check(chk_rval == even_chk(d), "R5 generated check", {56'd0, chk_rval}, {56'd0, even_chk(d)});
    endtask

    task automatic t_raw_write();
        logic [63:0] d = 64'hFFFF_0000_A5A5_0F0F;
        load_regs(d, 8'h5A);
        run_cmd(0, 1, 2'd1, 4'd9);
        load_regs(64'h0, 8'h00);
        run_cmd(1, 0, 2'd1, 4'd9);
        check(chk_rval == 8'h5A, "R6 raw check", {56'd0, chk_rval}, 64'h5A);
        check(dat_rval == d, "R6 raw data", dat_rval, d);
    endtask

    task automatic t_addr_compose();
        logic [63:0] a = 64'hAAAA_1111_2222_3333;
        logic [63:0] b = 64'h5555_4444_6666_7777;
        load_regs(a, 8'h00);
        run_cmd(0, 0, 2'd2, 4'd5);
        load_regs(b, 8'h00);
        run_cmd(0, 0, 2'd1, 4'd5);
        fn_read(6'h25, a, 0, "R2 chan2 entry5");
        fn_read(6'h15, b, 0, "R2 chan1 entry5");
    endtask

    task automatic t_busy_ignore();
        logic [63:0] keep = 64'hC0DE_C0DE_C0DE_C0DE;
        logic [63:0] other = 64'h1234_0000_0000_4321;
        load_regs(keep, 8'h00);
        run_cmd(0, 0, 2'd3, 4'd15);
        load_regs(other, 8'h00);
        @(negedge clk);
        cmd_we = 1; cmd_is_read = 0; cmd_raw_chk = 0; cmd_chan = 2'd0; cmd_entry = 4'd1;
        @(negedge clk);
        cmd_chan = 2'd3; cmd_entry = 4'd15;   // second command during busy
        check(acc_done == 1'b0, "R4 busy", {63'd0, acc_done}, 64'd0);
        @(negedge clk);
        cmd_we = 0;
        check(acc_done == 1'b0, "R4 busy cycle 2", {63'd0, acc_done}, 64'd0);
        @(negedge clk);
        check(acc_done == 1'b1, "R4 timing unchanged", {63'd0, acc_done}, 64'd1);
        fn_read(6'h3F, keep, 0, "R4 word untouched");
        fn_read(6'h01, other, 0, "R4 first command done");
    endtask

    task automatic t_parity_log();
        logic [63:0] d1 = 64'h0000_0000_0000_0001;
        logic [63:0] d2 = 64'h0000_0000_0000_0003;
        load_regs(d1, even_chk(d1) ^ 8'h01);
        run_cmd(0, 1, 2'd0, 4'd7);
        load_regs(d2, even_chk(d2) ^ 8'h80);
        run_cmd(0, 1, 2'd2, 4'd2);
        fn_read(6'h07, d1, 1, "R8 first error");
        check(log_valid == 1'b1, "R9 log set", {63'd0, log_valid}, 64'd1);
        check(log_addr == 6'h07, "R9 log addr", {58'd0, log_addr}, 64'h07);
        fn_read(6'h22, d2, 1, "R8 strobe with log full");
        check(log_addr == 6'h07, "R9 log keeps first", {58'd0, log_addr}, 64'h07);
        @(negedge clk);
        perr_clr = 1;
        @(negedge clk);
        perr_clr = 0;
        check(log_valid == 1'b0, "R10 cleared", {63'd0, log_valid}, 64'd0);
        fn_read(6'h22, d2, 1, "R10 rearmed error");
        check(log_addr == 6'h22, "R10 new addr", {58'd0, log_addr}, 64'h22);
        // clear coincident with a new error
        @(negedge clk);
        fn_re = 1; fn_addr = 6'h07;
        @(negedge clk);
        fn_re = 0; perr_clr = 1;
        check(perr_strobe == 1'b1, "R10 coincident strobe", {63'd0, perr_strobe}, 64'd1);
        @(negedge clk);
        perr_clr = 0;
        check(log_valid == 1'b1, "R10 coincident logged", {63'd0, log_valid}, 64'd1);
        check(log_addr == 6'h07, "R10 coincident addr", {58'd0, log_addr}, 64'h07);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_gen_write_read();
        t_raw_write();
        t_addr_compose();
        t_busy_ignore();
        t_parity_log();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule